// File: doc/BRIEF.md
# Configuration Word Loader with Complement Check

After each reset this block fetches a short, fixed area of configuration words from a synchronous read port. Every 32-bit word holds two 16-bit pairs, and each pair is a value byte in its low half with the bitwise complement of that value in its high half. The loader checks every pair against its complement. A failing pair is replaced by 0xFF and raises a sticky error flag. An all-ones pair counts as an erased, valid entry. When the last word has been checked, the loader raises `done`. From then on it presents latched configuration: the access-protection state, a system configuration byte with two decoded bits, two user data bytes and a packed per-sector erase/write protection vector.

The read port is a plain fixed-latency port and has no back-pressure. The loader drives `rd_en` and `rd_addr` for one cycle per word. The memory must return `rd_data` exactly one cycle later and cannot stall. There is no valid/ready stream at the block's edge. The configuration outputs are control-level levels that hold steady once `done` is high. New contents of the configuration area take effect only when reset causes a reload. Until `done`, every output holds a conservative default.

Top module: `cfg_word_loader`

## Requirements
- R1: In the first four cycles after reset release, `rd_en` is high and `rd_addr` counts 0, 1, 2 and 3, one value per cycle. After that, `rd_en` stays low until the next reset.
- R2: `done` goes high in the cycle after the word read at address 3 has been checked. It stays high until reset.
- R3: A pair is valid when bits [15:8] equal the bitwise inverse of bits [7:0]. A valid pair loads its low byte as the value.
- R4: The pair 0xFFFF is valid and loads 0xFF. It does not raise the error flag.
- R5: Any other pair that fails the check loads 0xFF as its value and sets `data_err`.
- R6: `data_err` is cleared by reset. It becomes set if any of the eight pairs fails, and stays set until the next reset.
- R7: `acc_prot_on` is 0 only when the loaded access-protection byte equals 0xA5. Any other loaded value, including a forced 0xFF, gives 1.
- R8: The pair index runs low half then high half, word 0 up to word 3. Pair 0 is the access-protection byte and pair 1 is `sys_cfg`. Pair 2 is `user0` and pair 3 is `user1`. Pairs 4 to 7 are bytes 0 to 3 of `wp_open`, with pair 4 in bits [7:0]. Bit n of `wp_open` covers sector n: 0 means protected and 1 means open.
- R9: While `done` is low, the outputs take these values: `acc_prot_on` is 1, `wp_open` is all zeros, and `sys_cfg`, `user0` and `user1` are 0xFF.
- R10: `boot_bank1_only` equals `sys_cfg` bit 3. `wdt_auto_on` equals the inverse of `sys_cfg` bit 0, so 0 in that bit means the watchdog is on.
- R11: Once `done` is high, the outputs do not follow later changes of the memory contents. The next reset reloads them from the current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts a load |
| rd_en | output | 1 | Read strobe to the configuration memory |
| rd_addr | output | 2 | Word address of the read |
| rd_data | input | 32 | Read data, valid one cycle after `rd_en` |
| done | output | 1 | Load finished; outputs valid |
| data_err | output | 1 | Sticky: at least one pair failed its check |
| acc_prot_on | output | 1 | Access protection active |
| sys_cfg | output | 8 | Loaded system configuration byte |
| user0 | output | 8 | Loaded user data byte 0 |
| user1 | output | 8 | Loaded user data byte 1 |
| wp_open | output | 32 | Per-sector erase/write protection, 1 = open |
| boot_bank1_only | output | 1 | Boot option bit from `sys_cfg` |
| wdt_auto_on | output | 1 | Watchdog auto-enable, decoded active high |

## Verification
The hardest cases to reach from the ports are the corners of the pair check. One is a pair that is all ones, which must load without an error. Another is a low byte of 0xFF under a high byte of 0x00, which is also valid. A third is a single bad pair that sits among valid ones in the last word, so the error must appear while every other field still loads. The bench models the memory and rewrites its words before each reset, which lets it place exactly these patterns at chosen pair positions, including a bad access-protection pair and a 0x0000 pair. It also changes the memory after `done` to show that the outputs hold, and that only the next reset picks up the new contents.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int BYTE_W      = 8;
  localparam int PAIR_W      = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] PROT_OPEN   = 8'hA5;

  // Index of each named field in the flat pair order
  localparam int IDX_PROT  = 0;
  localparam int IDX_SYS   = 1;
  localparam int IDX_USER0 = 2;
  localparam int IDX_USER1 = 3;
  localparam int IDX_WP0   = 4;

  // Bit positions inside the system configuration byte
  localparam int SYS_BOOT_BIT = 3;
  localparam int SYS_WDT_BIT  = 0;
endpackage

// File: rtl/cfgl_seq.sv
// Issues one read per word after reset and tracks which word returns.
module cfgl_seq #(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_vld,
  output logic [ADDR_W-1:0] word_idx,
  output logic              word_last
);
  localparam logic [ADDR_W:0]   CNT_END  = (ADDR_W+1)'(WORDS);
  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(WORDS - 1);

  logic [ADDR_W:0]   cnt_q;
  logic              vld_q;
  logic [ADDR_W-1:0] idx_q;

  assign rd_en   = (cnt_q < CNT_END);
  assign rd_addr = cnt_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (rd_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Read data comes back one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= rd_en;
      idx_q <= rd_addr;
    end
  end

  assign word_vld  = vld_q;
  assign word_idx  = idx_q;
  assign word_last = vld_q && (idx_q == IDX_LAST);
endmodule

// File: rtl/cfgl_pair_chk.sv
// Validates one value/complement pair; a bad pair yields the erased value.
module cfgl_pair_chk
  import cfgl_pkg::*;
(
  input  logic [PAIR_W-1:0] pair,
  output logic [BYTE_W-1:0] val,
  output logic              bad
);
  logic [BYTE_W-1:0] lo_b;
  logic [BYTE_W-1:0] hi_b;
  logic              compl_ok;
  logic              erased;

  assign lo_b     = pair[BYTE_W-1:0];
  assign hi_b     = pair[PAIR_W-1:BYTE_W];
  assign compl_ok = (hi_b == ~lo_b);
  assign erased   = &pair;
  assign bad      = !(compl_ok || erased);
  assign val      = bad ? ERASED_BYTE : lo_b;
endmodule

// File: rtl/cfgl_store.sv
// Holds checked bytes, the sticky error and done; gates outputs to defaults.
module cfgl_store
  import cfgl_pkg::*;
#(
  parameter int PPW    = 2,
  parameter int NPAIRS = 8,
  parameter int ADDR_W = 2,
  parameter int WP_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_vld,
  input  logic [ADDR_W-1:0]     word_idx,
  input  logic                  word_last,
  input  logic [PPW*BYTE_W-1:0] word_vals,
  input  logic [PPW-1:0]        word_bads,
  output logic                  done,
  output logic                  data_err,
  output logic                  acc_prot_on,
  output logic [BYTE_W-1:0]     sys_cfg,
  output logic [BYTE_W-1:0]     user0,
  output logic [BYTE_W-1:0]     user1,
  output logic [WP_W-1:0]       wp_open,
  output logic                  boot_bank1_only,
  output logic                  wdt_auto_on
);
  localparam int WP_BYTES = WP_W / BYTE_W;

  logic [BYTE_W-1:0] byte_q [NPAIRS];
  logic              done_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIRS; i++) byte_q[i] <= ERASED_BYTE;
    end else if (word_vld) begin
      for (int p = 0; p < PPW; p++) begin
        byte_q[int'(word_idx) * PPW + p] <= word_vals[p*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (word_vld && (|word_bads)) err_q <= 1'b1;
      if (word_last) done_q <= 1'b1;
    end
  end

  assign done     = done_q;
  assign data_err = err_q;

  // Safe values until the whole area has been checked
  assign acc_prot_on = !(done_q && (byte_q[IDX_PROT] == PROT_OPEN));
  assign sys_cfg     = done_q ? byte_q[IDX_SYS]   : ERASED_BYTE;
  assign user0       = done_q ? byte_q[IDX_USER0] : ERASED_BYTE;
  assign user1       = done_q ? byte_q[IDX_USER1] : ERASED_BYTE;

  for (genvar b = 0; b < WP_BYTES; b++) begin : g_wp
    assign wp_open[b*BYTE_W +: BYTE_W] = done_q ? byte_q[IDX_WP0 + b] : '0;
  end

  assign boot_bank1_only = sys_cfg[SYS_BOOT_BIT];
  assign wdt_auto_on     = !sys_cfg[SYS_WDT_BIT];
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfgl_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(WORDS),
  parameter int WP_W   = (WORDS * (DATA_W / 16) - 4) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              data_err,
  output logic              acc_prot_on,
  output logic [7:0]        sys_cfg,
  output logic [7:0]        user0,
  output logic [7:0]        user1,
  output logic [WP_W-1:0]   wp_open,
  output logic              boot_bank1_only,
  output logic              wdt_auto_on
);
  localparam int PPW    = DATA_W / PAIR_W;
  localparam int NPAIRS = WORDS * PPW;

  logic              word_vld;
  logic [ADDR_W-1:0] word_idx;
  logic              word_last;
  logic [PPW*BYTE_W-1:0] word_vals;
  logic [PPW-1:0]        word_bads;

  cfgl_seq #(.WORDS(WORDS), .ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .word_vld  (word_vld),
    .word_idx  (word_idx),
    .word_last (word_last)
  );

  for (genvar p = 0; p < PPW; p++) begin : g_pair
    cfgl_pair_chk pchk_i (
      .pair (rd_data[p*PAIR_W +: PAIR_W]),
      .val  (word_vals[p*BYTE_W +: BYTE_W]),
      .bad  (word_bads[p])
    );
  end

  cfgl_store #(
    .PPW(PPW), .NPAIRS(NPAIRS), .ADDR_W(ADDR_W), .WP_W(WP_W)
  ) store_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .word_vld        (word_vld),
    .word_idx        (word_idx),
    .word_last       (word_last),
    .word_vals       (word_vals),
    .word_bads       (word_bads),
    .done            (done),
    .data_err        (data_err),
    .acc_prot_on     (acc_prot_on),
    .sys_cfg         (sys_cfg),
    .user0           (user0),
    .user1           (user1),
    .wp_open         (wp_open),
    .boot_bank1_only (boot_bank1_only),
    .wdt_auto_on     (wdt_auto_on)
  );
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 2,
  parameter int WP_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              data_err,
  input logic              acc_prot_on,
  input logic [7:0]        sys_cfg,
  input logic [7:0]        user0,
  input logic [7:0]        user1,
  input logic [WP_W-1:0]   wp_open
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  // R1
  no_read_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != LAST_ADDR) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |=> data_err);

  // R9
  safe_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (acc_prot_on && wp_open == '0 && sys_cfg == 8'hFF));

  // R11
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(acc_prot_on) && $stable(sys_cfg) && $stable(user0)
              && $stable(user1) && $stable(wp_open)));
endmodule

bind cfg_word_loader cfgl_chk #(
  .WORDS(WORDS), .ADDR_W(ADDR_W), .WP_W(WP_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .done        (done),
  .data_err    (data_err),
  .acc_prot_on (acc_prot_on),
  .sys_cfg     (sys_cfg),
  .user0       (user0),
  .user1       (user1),
  .wp_open     (wp_open)
);

// File: tb/cfg_word_loader_tb_top.sv
module cfg_word_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        done, data_err, acc_prot_on, boot_bank1_only, wdt_auto_on;
  logic [7:0]  sys_cfg, user0, user1;
  logic [31:0] wp_open;

  always #10 clk = ~clk;  // 50 MHz

  cfg_word_loader dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .data_err(data_err), .acc_prot_on(acc_prot_on), .sys_cfg(sys_cfg),
    .user0(user0), .user1(user1), .wp_open(wp_open),
    .boot_bank1_only(boot_bank1_only), .wdt_auto_on(wdt_auto_on)
  );

  // Memory model: one cycle read latency
  logic [31:0] mem [4];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  typedef struct packed {
    logic        prot;
    logic [7:0]  sys;
    logic [7:0]  u0;
    logic [7:0]  u1;
    logic [31:0] wp;
    logic        err;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   checks = 0;
  int   errors = 0;
  int   nrd = 0;
  bit   seen = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pr(logic [7:0] v);
    return {~v, v};
  endfunction

  // returns {bad, value}
  function automatic logic [8:0] ref_pair(logic [15:0] p);
    if (p[15:8] == ~p[7:0] || p == 16'hFFFF) return {1'b0, p[7:0]};
    return {1'b1, 8'hFF};
  endfunction

  function automatic exp_t predict(logic [31:0] w0, logic [31:0] w1,
                                   logic [31:0] w2, logic [31:0] w3);
    exp_t e;
    logic [8:0] r [8];
    r[0] = ref_pair(w0[15:0]);  r[1] = ref_pair(w0[31:16]);
    r[2] = ref_pair(w1[15:0]);  r[3] = ref_pair(w1[31:16]);
    r[4] = ref_pair(w2[15:0]);  r[5] = ref_pair(w2[31:16]);
    r[6] = ref_pair(w3[15:0]);  r[7] = ref_pair(w3[31:16]);
    e.prot = (r[0][7:0] != 8'hA5);
    e.sys  = r[1][7:0];
    e.u0   = r[2][7:0];
    e.u1   = r[3][7:0];
    e.wp   = {r[7][7:0], r[6][7:0], r[5][7:0], r[4][7:0]};
    e.err  = r[0][8] | r[1][8] | r[2][8] | r[3][8] | r[4][8] | r[5][8] | r[6][8] | r[7][8];
    return e;
  endfunction

  task automatic compare_all(exp_t e, string tag);
    chk("R7", {tag, " acc_prot_on"}, 32'(acc_prot_on), 32'(e.prot));
    chk("R8", {tag, " sys_cfg"}, 32'(sys_cfg), 32'(e.sys));
    chk("R8", {tag, " user0"}, 32'(user0), 32'(e.u0));
    chk("R8", {tag, " user1"}, 32'(user1), 32'(e.u1));
    chk("R5", {tag, " wp_open"}, wp_open, e.wp);
    chk("R6", {tag, " data_err"}, 32'(data_err), 32'(e.err));
    chk("R10", {tag, " boot_bank1_only"}, 32'(boot_bank1_only), 32'(e.sys[3]));
    chk("R10", {tag, " wdt_auto_on"}, 32'(wdt_auto_on), 32'(!e.sys[0]));
  endtask

  // Monitor: read order and scoreboard comparison at done
  always @(negedge clk) begin
    if (!rst_n) begin
      nrd  = 0;
      seen = 0;
    end else begin
      if (rd_en) begin
        chk("R1", "read address", 32'(rd_addr), 32'(nrd));
        nrd++;
      end
      if (done && !seen) begin
        seen = 1;
        chk("R1", "reads before done", 32'(nrd), 32'd4);
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2 done without expected item: actual 1 expected 0");
        end else begin
          last_exp = exp_q.pop_front();
          compare_all(last_exp, "scoreboard");
        end
      end
    end
  end

  task automatic run_case(logic [31:0] w0, logic [31:0] w1,
                          logic [31:0] w2, logic [31:0] w3);
    mem[0] = w0; mem[1] = w1; mem[2] = w2; mem[3] = w3;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.push_back(predict(w0, w1, w2, w3));
    // reset state, R6 cleared, R9 defaults
    chk("R2", "done in reset", 32'(done), 32'd0);
    chk("R6", "data_err in reset", 32'(data_err), 32'd0);
    chk("R9", "prot in reset", 32'(acc_prot_on), 32'd1);
    chk("R9", "wp_open in reset", wp_open, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "done during load", 32'(done), 32'd0);
    chk("R9", "user0 during load", 32'(user0), 32'hFF);
    chk("R9", "wp_open during load", wp_open, 32'd0);
    for (int i = 0; i < 20 && !seen; i++) @(negedge clk);
    chk("R2", "done reached", 32'(seen), 32'd1);
    repeat (3) @(negedge clk);
    chk("R2", "done held", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R3: all pairs valid, protection open
    run_case({pr(8'h5C), pr(8'hA5)}, {pr(8'h3C), pr(8'h12)},
             {pr(8'hF0), pr(8'h0F)}, {pr(8'hAA), pr(8'h55)});
    // R4: fully erased area
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R5: one bad pair in the last word
    run_case({pr(8'h5C), pr(8'hA5)}, {pr(8'h3C), pr(8'h12)},
             {pr(8'hF0), pr(8'h0F)}, {16'h12AA, pr(8'h55)});
    // R7: bad access-protection pair with 0xA5 in its low byte
    run_case({pr(8'h08), 16'h00A5}, {pr(8'h00), pr(8'h77)},
             {pr(8'h01), pr(8'h80)}, {pr(8'hFF), pr(8'hFE)});
    // R4/R3: low FF under high 00 is valid; 0x0000 pair is bad
    run_case({pr(8'h01), pr(8'h5A)}, {16'h0000, 16'h00FF},
             {pr(8'h00), pr(8'h00)}, {pr(8'hC3), 16'hFF00});
    // R11: outputs hold after done while memory changes
    mem[0] = {pr(8'h00), pr(8'hA5)};
    mem[1] = 32'h0;
    mem[2] = 32'hFFFF_FFFF;
    mem[3] = 32'hFFFF_FFFF;
    repeat (10) @(negedge clk);
    compare_all(last_exp, "R11 hold");
    // R11: reset reloads the new contents
    run_case(mem[0], mem[1], mem[2], mem[3]);
    repeat (2) @(negedge clk);
    chk("R2", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule